// File: doc/BRIEF.md
# Chip-Select Bank Decoder

This block sits between a bus address and a set of external memory devices. It compares every access against a table of programmable banks and raises the chip select of the bank that claims the address. Each bank has two 32-bit registers. The first holds the bank's base address, a valid flag, a write-protect flag, a port-size code and a code naming the timing machine that serves the bank. The second holds the address mask. Along with the chip select, the decoder reports the machine code and the port size of the selected bank. The timing machine that then runs the bus cycle lies outside this block.

The decoder flags three kinds of fault in a sticky status register: a write that hits a protected bank, an access that no valid bank claims, and a timeout pulse from the external bus monitor. Software clears a status bit by writing 1 to it. A disable register, with its bits at the same positions, stops each fault class from being recorded. When an address fault (protect or no-match) is recorded, the decoder latches the address of the failing access.

Configuration goes through one write port and one read port, addressed by `cfg_addr`:
- Locations 0 to 2·NBANK−1 hold the bank registers. Bank b's base register is at 2b and its mask register is at 2b+1.
- Location 2·NBANK is the status register.
- Location 2·NBANK+1 is the disable register.
- Location 2·NBANK+2 is the error address, which can only be read.

Outputs are registered. They reflect the access presented on the previous clock edge and last for one cycle per access.

Top module: `csbank_decode`

## Requirements
- R1: After reset, every bank register, the status register, the disable register and the error address read as 0. Every bank is therefore invalid, and an access selects nothing.
- R2: A bank claims an address when, over bits 31:15, (address AND mask) equals (base AND mask). Base and address bits 14:0 never affect the compare, so the smallest bank is 32 KB.
- R3: A bank takes part in decoding only while bit 0 of its base register is 1.
- R4: When several valid banks claim the same address, the lowest-numbered bank is selected. Exactly one `cs_o` bit is set, bit b for bank b.
- R5: One cycle after an access with a successful select:
  - `hit_o` is 1 and `cs_o` is set.
  - `mach_o` carries base bits 7:5. Code 000 is the general-purpose machine, 001 the NAND flash machine, and 100, 101 and 110 are programmable machines A, B and C.
  - `psize_o` carries base bits 12:11. Code 01 is 8-bit, 10 is 16-bit and 11 is 32-bit.
  - In every other cycle, `hit_o`, `cs_o`, `mach_o` and `psize_o` are 0.
- R6: A write whose selected bank has base bit 8 set drives no chip select and sets status bit 26. A read of the same bank is served normally.
- R7: An access that no valid bank claims drives no chip select and sets status bit 19.
- R8: A 1 in disable bit 31, 26 or 19 stops the matching status bit from being set. It does not change which chip select is driven. Only bits 31, 26 and 19 of the disable and status registers are stored; all other bits read 0.
- R9: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it as it is. If a new event arrives in the same cycle as the clear, the bit stays set.
- R10: The error address register loads the access address only when a protect or no-match fault is recorded. Otherwise it holds its value.
- R11: A pulse on `tmo_evt` sets status bit 31.
- R12: A mask of all zeros in bits 31:15 makes a valid bank claim the whole 4 GB space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | RAW | Configuration register location |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data at `cfg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| tmo_evt | input | 1 | Bus monitor timeout pulse |
| cs_o | output | NBANK | One-hot chip select, bit b for bank b |
| hit_o | output | 1 | Access was served by a bank |
| mach_o | output | 3 | Timing machine code of the selected bank |
| psize_o | output | 2 | Port size code of the selected bank |

## Verification
The bench checks the edge of a 32 KB bank: the last word inside it must hit, and the first word past it must miss. A compare that included bit 14 or below, or that dropped bit 15, fails one of these two accesses. Two valid banks claim overlapping space, so a priority encoder that favours the highest bank returns the wrong select. A protected write must produce no select while a read of the same bank still works; a decoder that ignores the direction gets one of these wrong. The bench also covers a disabled fault class, which must leave the status bit and the error address untouched. Finally, it clears status bit 19 in the same cycle that a miss sets it again. If the clear wins, the bit drops and the bench reports it.

// File: rtl/csbank_decode.sv
module csbank_decode #(
  parameter int NBANK = 8,
  parameter int RAW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RAW-1:0]   cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [31:0]      acc_addr,
  input  logic             tmo_evt,
  output logic [NBANK-1:0] cs_o,
  output logic             hit_o,
  output logic [2:0]       mach_o,
  output logic [1:0]       psize_o
);
  localparam int IW     = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int A_STAT = 2 * NBANK;
  localparam int A_DIS  = 2 * NBANK + 1;
  localparam int A_EADR = 2 * NBANK + 2;
  localparam int B_TMO  = 31;
  localparam int B_WP   = 26;
  localparam int B_CS   = 19;
  localparam logic [31:0] EMASK = (32'd1 << B_TMO) | (32'd1 << B_WP) | (32'd1 << B_CS);

  logic [31:0] base_q [NBANK];
  logic [31:0] mask_q [NBANK];
  logic [NBANK-1:0] match;
  logic [31:0] stat_q, dis_q, eadr_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        base_q[b] <= '0;
        mask_q[b] <= '0;
      end else if (cfg_we && cfg_addr == RAW'(2*b))   base_q[b] <= cfg_wdata;
      else if     (cfg_we && cfg_addr == RAW'(2*b+1)) mask_q[b] <= cfg_wdata;

    assign match[b] = base_q[b][0] &&
                      (((acc_addr[31:15] ^ base_q[b][31:15]) & mask_q[b][31:15]) == '0);
  end

  logic [IW-1:0] win;
  always_comb begin
    win = '0;
    for (int b = NBANK-1; b >= 0; b--)
      if (match[b]) win = IW'(b);
  end

  wire        any    = |match;
  wire [31:0] wbase  = base_q[win];
  wire        wp_blk = any && acc_write && wbase[8];
  wire        serve  = acc_valid && any && !wp_blk;
  wire        ev_cs  = acc_valid && !any;
  wire        ev_wp  = acc_valid && wp_blk;

  wire [31:0] set_v  = ({tmo_evt, 31'd0} | (32'(ev_wp) << B_WP) | (32'(ev_cs) << B_CS)) & ~dis_q;
  wire        st_wr  = cfg_we && cfg_addr == RAW'(A_STAT);
  wire [31:0] clr_v  = st_wr ? cfg_wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q  <= '0;
      dis_q   <= '0;
      eadr_q  <= '0;
      cs_o    <= '0;
      hit_o   <= 1'b0;
      mach_o  <= '0;
      psize_o <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr_v) | set_v) & EMASK;
      if (cfg_we && cfg_addr == RAW'(A_DIS)) dis_q <= cfg_wdata & EMASK;
      if ((ev_cs && !dis_q[B_CS]) || (ev_wp && !dis_q[B_WP])) eadr_q <= acc_addr;
      cs_o    <= serve ? (NBANK'(1) << win) : '0;
      hit_o   <= serve;
      mach_o  <= serve ? wbase[7:5] : 3'd0;
      psize_o <= serve ? wbase[12:11] : 2'd0;
    end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < RAW'(A_STAT))
      cfg_rdata = cfg_addr[0] ? mask_q[cfg_addr[IW:1]] : base_q[cfg_addr[IW:1]];
    else if (cfg_addr == RAW'(A_STAT)) cfg_rdata = stat_q;
    else if (cfg_addr == RAW'(A_DIS))  cfg_rdata = dis_q;
    else if (cfg_addr == RAW'(A_EADR)) cfg_rdata = eadr_q;
  end

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));
  p_cs_from_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o != '0) |-> $past(acc_valid));
  p_hit_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o == (cs_o != '0));
  p_wp_no_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[B_WP]) |-> (cs_o == '0) && $past(acc_valid && acc_write));
  p_cs_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[B_CS]) |-> $past(acc_valid && !dis_q[B_CS]));
  p_w1c_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[B_CS]) |-> $past(cfg_we && cfg_addr == RAW'(A_STAT) && cfg_wdata[B_CS]));
  p_eadr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eadr_q) |-> $past(acc_valid));
  p_tmo_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[B_TMO]) |-> $past(tmo_evt && !dis_q[B_TMO]));
endmodule

// File: tb/csbank_decode_tb.sv
`timescale 1ns/1ps
module csbank_decode_tb_top;
  localparam int NB = 8;
  localparam logic [4:0] STAT = 5'd16, DIS = 5'd17, EADR = 5'd18;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [4:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic acc_valid = 0, acc_write = 0, tmo_evt = 0; logic [31:0] acc_addr = 0;
  logic [NB-1:0] cs_o; logic hit_o; logic [2:0] mach_o; logic [1:0] psize_o;
  int checks = 0, fails = 0; bit done = 0;

  always #2.5 clk = ~clk;

  csbank_decode #(.NBANK(NB), .RAW(5)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic acc(input logic [31:0] a, input logic w);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_write = w;
    @(negedge clk); acc_valid = 0; acc_write = 0;
  endtask

  task automatic out(input string req, input logic [NB-1:0] cs, input logic [2:0] m, input logic [1:0] p);
    chk({req, " cs"}, 32'(cs_o), 32'(cs));
    chk({req, " hit"}, 32'(hit_o), 32'(cs != 0));
    chk({req, " mach"}, 32'(mach_o), 32'(m));
    chk({req, " psize"}, 32'(psize_o), 32'(p));
  endtask

  task automatic t_reset;
    rd("R1 base0", 5'd0, 0); rd("R1 mask7", 5'd15, 0);
    rd("R1 status", STAT, 0); rd("R1 disable", DIS, 0); rd("R1 eaddr", EADR, 0);
    acc(32'h0000_1000, 0); out("R1 no bank", 0, 0, 0);
    rd("R7 miss flag", STAT, 32'h0008_0000);
    rd("R10 miss addr", EADR, 32'h0000_1000);
    wr(STAT, 32'h0008_0000); rd("R9 clear", STAT, 0);
  endtask

  task automatic t_basic;
    wr(5'd4, 32'h4000_1821); wr(5'd5, 32'hFFFF_8000);
    acc(32'h4000_7FFC, 0); out("R2 R5 inside", 8'h04, 3'd1, 2'd3);
    @(negedge clk); out("R5 idle", 0, 0, 0);
    acc(32'h4000_8000, 0); out("R2 past edge", 0, 0, 0);
    wr(5'd6, 32'h5000_0880); wr(5'd7, 32'hFFFF_8000);
    acc(32'h5000_0000, 0); out("R3 invalid", 0, 0, 0);
    wr(STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_prio;
    wr(5'd10, 32'h4000_0881); wr(5'd11, 32'hF000_0000);
    acc(32'h4000_0010, 1); out("R4 low wins", 8'h04, 3'd1, 2'd3);
    acc(32'h4100_0000, 0); out("R4 only b5", 8'h20, 3'd4, 2'd1);
  endtask

  task automatic t_wp;
    wr(5'd2, 32'h8000_11A1); wr(5'd3, 32'hFFF0_0000);
    wr(STAT, 32'hFFFF_FFFF);
    acc(32'h8000_0040, 1); out("R6 blocked", 0, 0, 0);
    rd("R6 flag", STAT, 32'h0400_0000);
    rd("R10 wp addr", EADR, 32'h8000_0040);
    acc(32'h8000_0080, 0); out("R6 read ok", 8'h02, 3'd5, 2'd2);
    rd("R10 hold", EADR, 32'h8000_0040);
  endtask

  task automatic t_disable;
    wr(DIS, 32'hFFFF_FFFF); rd("R8 disable bits", DIS, 32'h8408_0000);
    wr(DIS, 32'h0408_0000); wr(STAT, 32'hFFFF_FFFF);
    acc(32'h8000_0040, 1); out("R8 still blocked", 0, 0, 0);
    acc(32'h2000_0000, 0);
    rd("R8 no record", STAT, 0);
    rd("R8 R10 eaddr kept", EADR, 32'h8000_0040);
    @(negedge clk); tmo_evt = 1; @(negedge clk); tmo_evt = 0;
    rd("R11 timeout", STAT, 32'h8000_0000);
    wr(DIS, 32'h8000_0000); wr(STAT, 32'hFFFF_FFFF);
    @(negedge clk); tmo_evt = 1; @(negedge clk); tmo_evt = 0;
    rd("R8 tmo masked", STAT, 0);
    wr(DIS, 0);
  endtask

  task automatic t_w1c;
    @(negedge clk); tmo_evt = 1; @(negedge clk); tmo_evt = 0;
    acc(32'h2000_0000, 0);
    rd("R9 sticky", STAT, 32'h8008_0000);
    wr(STAT, 32'h8000_0000); rd("R9 one bit", STAT, 32'h0008_0000);
    wr(STAT, 32'h0); rd("R9 zero write", STAT, 32'h0008_0000);
    @(negedge clk); cfg_we = 1; cfg_addr = STAT; cfg_wdata = 32'h0008_0000;
    acc_valid = 1; acc_addr = 32'h2000_0004;
    @(negedge clk); cfg_we = 0; acc_valid = 0;
    rd("R9 set beats clear", STAT, 32'h0008_0000);
  endtask

  task automatic t_whole;
    wr(5'd0, 32'h0000_0001); wr(5'd1, 32'h0);
    acc(32'hFFFF_FFF0, 0); out("R12 4GB", 8'h01, 3'd0, 2'd0);
    acc(32'h4000_0000, 0); out("R12 R4 bank0", 8'h01, 3'd0, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_basic; t_prio; t_wp; t_disable; t_w1c; t_whole;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule